// File: doc/BRIEF.md
# Status Word Flag Update Unit

This block keeps a 16-bit processor status word and revises its arithmetic indicators each time an instruction completes. The word uses big-end numbering: bit 0 is the most significant bit. Each instruction presents a set of results: an overflow class, a carry-out, a condition code, and the instruction word. Separate strobes say which of those results apply. The block keeps four fields up to date: the right-stack-op pending bit (bit 3), the overflow bit (bit 4), the carry bit (bit 5) and the condition code (bits 6 and 7). It reads the user-trap enable (bit 2) to decide whether an overflow class becomes a trap request toward interrupt logic.

A software write port loads the whole word. Two limits apply to it. In user mode it may not alter the pending bit. It also never stores the unused condition-code value 11.

A two-state trap sequencer turns a qualifying overflow into a one-cycle request that carries a cause code. Its states are `TS_IDLE`, where no request is raised, and `TS_FIRE`, where the request is raised. `TS_IDLE -> TS_FIRE` on a trapping overflow. `TS_FIRE -> TS_FIRE` on a further trapping overflow in the next cycle. `TS_FIRE -> TS_IDLE` otherwise. Reset forces `TS_IDLE`.

Top module: `status_word_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all 16 status bits to zero and leaves `trap_req` low in the following cycle.
- R2: On an executed instruction (`step` high), bit 3 (vector index 12) becomes 1 when `instr_valid` is 1 and instruction bits 10..15 (vector bits [5:0]) are not all zero, since all zeros is NOP; otherwise it becomes 0.
- R3: A software write made while `user_mode` is 1 leaves bit 3 at its previous value. The other bits are loaded as usual.
- R4: A software write (`sw_we`) loads `sw_data` into the word and takes precedence over every instruction update made in the same cycle; in supervisor mode it may set bit 3.
- R5: With trap enable (bit 2, index 13) at 0 and `ovf_upd` high, any overflow class other than 0 sets bit 4 (index 11) and raises no trap. Class 0 clears bit 4.
- R6: With trap enable at 1, a non-integer overflow class (2 = float overflow, 3 = float underflow, 4..7 = other arithmetic) raises a trap and leaves bit 4 unchanged.
- R7: With trap enable at 1, an integer overflow (class 1) both sets bit 4 and raises a trap with cause 001.
- R8: When `carry_upd` is high on a step, bit 5 (index 10) takes the value of `carry_in`.
- R9: The condition code (bits 6..7, indices [9:8]) takes `cc_in` when `cc_upd` is high on a step. The value 11 is never stored, from either the instruction path or the write port; the field keeps its old value instead.
- R10: A field whose update strobe is low keeps its value on a step, and `ovf_upd` low raises no trap.
- R11: `trap_req` is high for exactly the cycle after a trapping step and falls afterwards unless another trapping step follows. `trap_cause` is 001 for integer, 010 for float overflow, 011 for float underflow and 100 for other arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | An instruction completed this cycle |
| instr_word | input | IW_W | Executed instruction word |
| instr_valid | input | 1 | Qualifies the right stack-op field |
| ovf_upd | input | 1 | Overflow field update strobe |
| ovf_class | input | 3 | 0 none, 1 integer, 2 float over, 3 float under, 4..7 other |
| carry_upd | input | 1 | Carry field update strobe |
| carry_in | input | 1 | Carry out of the MSB |
| cc_upd | input | 1 | Condition-code update strobe |
| cc_in | input | 2 | Condition-code result |
| user_mode | input | 1 | Processor is in user mode |
| sw_we | input | 1 | Software write enable |
| sw_data | input | 16 | Software write data |
| status | output | 16 | Status word, index 15 is bit 0 |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 3 | Cause of the current trap request |

## Verification
Every result is registered once. The status word, `trap_req` and `trap_cause` all reflect a stimulus exactly one rising edge after it is applied. The bench drives each vector on a falling edge and lets a single rising edge pass. It then samples one nanosecond later, before the next falling edge changes any input. The bench checks the pulse falling with an idle cycle immediately after a trapping step, and checks back-to-back traps with consecutive trapping vectors.

// File: rtl/swu_pkg.sv
package swu_pkg;
    localparam int SW_W = 16;
    // Status bits are numbered from the MSB; index = SW_W-1-bit
    localparam int B_TE  = SW_W - 1 - 2;
    localparam int B_RS  = SW_W - 1 - 3;
    localparam int B_OV  = SW_W - 1 - 4;
    localparam int B_CY  = SW_W - 1 - 5;
    localparam int CC_HI = SW_W - 1 - 6;
    localparam int CC_LO = SW_W - 1 - 7;

    localparam logic [1:0] CC_BAD = 2'b11;

    localparam logic [2:0] OC_NONE = 3'd0;
    localparam logic [2:0] OC_INT  = 3'd1;
    localparam logic [2:0] OC_FOVF = 3'd2;
    localparam logic [2:0] OC_FUNF = 3'd3;

    typedef enum logic [2:0] {
        TC_NONE  = 3'b000,
        TC_INT   = 3'b001,
        TC_FOVF  = 3'b010,
        TC_FUNF  = 3'b011,
        TC_ARITH = 3'b100
    } trap_cause_e;

    typedef enum logic {
        TS_IDLE,
        TS_FIRE
    } trap_state_e;
endpackage

// File: rtl/swu_rstack_detect.sv
module swu_rstack_detect #(
    parameter int IW_W = 16
) (
    input  logic [IW_W-1:0] instr_word,
    input  logic            instr_valid,
    output logic            rs_pending
);
    // right op field: instruction bits 10..15 in MSB-first numbering
    localparam int RF_HI = IW_W - 1 - 10;
    localparam int RF_LO = IW_W - 1 - 15;

    logic [RF_HI-RF_LO:0] rfield;
    assign rfield     = instr_word[RF_HI:RF_LO];
    assign rs_pending = instr_valid && (rfield != '0);
endmodule

// File: rtl/swu_ovf_trap.sv
module swu_ovf_trap
    import swu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  logic       ovf_upd,
    input  logic [2:0] ovf_class,
    input  logic       trap_en,
    input  logic       ov_cur,
    output logic       ov_next,
    output logic       trap_req,
    output logic [2:0] trap_cause
);
    trap_state_e state_q, state_d;
    trap_cause_e cause_q, cause_d;
    logic        ovf_act;
    logic        fire;

    assign ovf_act = step && ovf_upd;
    assign fire    = ovf_act && trap_en && (ovf_class != OC_NONE);

    always_comb begin
        unique case (ovf_class)
            OC_NONE: cause_d = TC_NONE;
            OC_INT:  cause_d = TC_INT;
            OC_FOVF: cause_d = TC_FOVF;
            OC_FUNF: cause_d = TC_FUNF;
            default: cause_d = TC_ARITH;
        endcase
    end

    always_comb begin
        if (!ovf_act)                    ov_next = ov_cur;
        else if (ovf_class == OC_NONE)   ov_next = 1'b0;
        else if (!trap_en)               ov_next = 1'b1;
        else if (ovf_class == OC_INT)    ov_next = 1'b1;
        else                             ov_next = ov_cur;
    end

    always_comb begin
        unique case (state_q)
            TS_IDLE: state_d = fire ? TS_FIRE : TS_IDLE;
            TS_FIRE: state_d = fire ? TS_FIRE : TS_IDLE;
            default: state_d = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_IDLE;
            cause_q <= TC_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= fire ? cause_d : TC_NONE;
        end
    end

    always_comb begin
        unique case (state_q)
            TS_IDLE: begin
                trap_req   = 1'b0;
                trap_cause = TC_NONE;
            end
            TS_FIRE: begin
                trap_req   = 1'b1;
                trap_cause = cause_q;
            end
            default: begin
                trap_req   = 1'b0;
                trap_cause = TC_NONE;
            end
        endcase
    end
endmodule

// File: rtl/swu_word_next.sv
module swu_word_next
    import swu_pkg::*;
(
    input  logic [SW_W-1:0] cur,
    input  logic            step,
    input  logic            rs_pending,
    input  logic            ov_next,
    input  logic            carry_upd,
    input  logic            carry_in,
    input  logic            cc_upd,
    input  logic [1:0]      cc_in,
    input  logic            user_mode,
    input  logic            sw_we,
    input  logic [SW_W-1:0] sw_data,
    output logic [SW_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (sw_we) begin
            nxt = sw_data;
            if (user_mode)
                nxt[B_RS] = cur[B_RS];
            if (sw_data[CC_HI:CC_LO] == CC_BAD)
                nxt[CC_HI:CC_LO] = cur[CC_HI:CC_LO];
        end else if (step) begin
            nxt[B_RS] = rs_pending;
            nxt[B_OV] = ov_next;
            if (carry_upd)
                nxt[B_CY] = carry_in;
            if (cc_upd && (cc_in != CC_BAD))
                nxt[CC_HI:CC_LO] = cc_in;
        end
    end
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
    import swu_pkg::*;
#(
    parameter int IW_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [IW_W-1:0] instr_word,
    input  logic            instr_valid,
    input  logic            ovf_upd,
    input  logic [2:0]      ovf_class,
    input  logic            carry_upd,
    input  logic            carry_in,
    input  logic            cc_upd,
    input  logic [1:0]      cc_in,
    input  logic            user_mode,
    input  logic            sw_we,
    input  logic [15:0]     sw_data,
    output logic [15:0]     status,
    output logic            trap_req,
    output logic [2:0]      trap_cause
);
    logic [SW_W-1:0] word_q, word_d;
    logic            rs_pending;
    logic            ov_next;

    swu_rstack_detect #(.IW_W(IW_W)) u_rs (
        .instr_word (instr_word),
        .instr_valid(instr_valid),
        .rs_pending (rs_pending)
    );

    swu_ovf_trap u_ovf (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .ovf_upd   (ovf_upd),
        .ovf_class (ovf_class),
        .trap_en   (word_q[B_TE]),
        .ov_cur    (word_q[B_OV]),
        .ov_next   (ov_next),
        .trap_req  (trap_req),
        .trap_cause(trap_cause)
    );

    swu_word_next u_nx (
        .cur       (word_q),
        .step      (step),
        .rs_pending(rs_pending),
        .ov_next   (ov_next),
        .carry_upd (carry_upd),
        .carry_in  (carry_in),
        .cc_upd    (cc_upd),
        .cc_in     (cc_in),
        .user_mode (user_mode),
        .sw_we     (sw_we),
        .sw_data   (sw_data),
        .nxt       (word_d)
    );

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign status = word_q;
endmodule

// File: rtl/swu_checker.sv
module swu_checker
    import swu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        step,
    input logic        ovf_upd,
    input logic [2:0]  ovf_class,
    input logic        carry_upd,
    input logic        carry_in,
    input logic        user_mode,
    input logic        sw_we,
    input logic [15:0] status,
    input logic        trap_req,
    input logic [2:0]  trap_cause
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == '0) && !trap_req);

    p_user_keeps_rs_r3: assert property (@(posedge clk) disable iff (rst)
        $past(sw_we && user_mode) |-> status[B_RS] == $past(status[B_RS]));

    p_no_trap_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!status[B_TE]) |-> !trap_req);

    p_fp_trap_keeps_ov_r6: assert property (@(posedge clk) disable iff (rst)
        $past(step && !sw_we && ovf_upd && status[B_TE] &&
              ovf_class != OC_NONE && ovf_class != OC_INT)
        |-> trap_req && (status[B_OV] == $past(status[B_OV])));

    p_int_both_r7: assert property (@(posedge clk) disable iff (rst)
        $past(step && !sw_we && ovf_upd && status[B_TE] && ovf_class == OC_INT)
        |-> trap_req && status[B_OV] && trap_cause == TC_INT);

    p_carry_follow_r8: assert property (@(posedge clk) disable iff (rst)
        $past(step && !sw_we && carry_upd) |-> status[B_CY] == $past(carry_in));

    p_cc_legal_r9: assert property (@(posedge clk) disable iff (rst)
        status[CC_HI:CC_LO] != CC_BAD);

    p_carry_hold_r10: assert property (@(posedge clk) disable iff (rst)
        $past(!sw_we && !(step && carry_upd)) |-> $stable(status[B_CY]));

    p_trap_source_r11: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(step && ovf_upd) && trap_cause != TC_NONE);
endmodule

bind status_word_unit swu_checker u_chk (.*);

// File: tb/sim_status_word_unit.sv
`timescale 1ns/1ps
module sim_status_word_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        step, instr_valid, ovf_upd, carry_upd, carry_in, cc_upd;
    logic        user_mode, sw_we;
    logic [15:0] instr_word, sw_data;
    logic [2:0]  ovf_class;
    logic [1:0]  cc_in;
    logic [15:0] status;
    logic        trap_req;
    logic [2:0]  trap_cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    status_word_unit u0 (.*);

    typedef struct packed {
        logic        we;
        logic        usr;
        logic [15:0] wdata;
        logic        stp;
        logic [15:0] ins;
        logic        iv;
        logic        ou;
        logic [2:0]  oc;
        logic        cu;
        logic        ci;
        logic        ccu;
        logic [1:0]  cci;
        logic [15:0] e_stat;
        logic        e_trap;
        logic [2:0]  e_cause;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1,0,16'h2000,0,16'h0000,0,0,3'd0,0,0,0,2'd0,16'h2000,0,3'd0,4'd4},  // R4 set trap enable
        '{0,0,16'h0000,1,16'h0005,1,1,3'd1,0,0,0,2'd0,16'h3800,1,3'd1,4'd7},  // R7 integer: flag+trap
        '{0,0,16'h0000,1,16'h0040,1,1,3'd2,0,0,0,2'd0,16'h2800,1,3'd2,4'd6},  // R6 float ovf, R2 NOP field
        '{0,0,16'h0000,1,16'h003F,0,1,3'd3,1,1,0,2'd0,16'h2C00,1,3'd3,4'd8},  // R8 carry, R6 underflow
        '{0,0,16'h0000,1,16'h0000,0,1,3'd5,0,0,1,2'd1,16'h2D00,1,3'd4,4'd11}, // R11 other arith
        '{0,0,16'h0000,1,16'h0000,0,0,3'd1,0,0,1,2'd3,16'h2D00,0,3'd0,4'd9},  // R9 cc 11 ignored, R10
        '{1,1,16'h1200,0,16'h0000,0,0,3'd0,0,0,0,2'd0,16'h0200,0,3'd0,4'd3},  // R3 user write
        '{0,0,16'h0000,1,16'h0001,1,1,3'd1,1,0,0,2'd0,16'h1A00,0,3'd0,4'd5},  // R5 flag, no trap
        '{1,1,16'h0800,0,16'h0000,0,0,3'd0,0,0,0,2'd0,16'h1800,0,3'd0,4'd3},  // R3 keep bit 3 = 1
        '{0,0,16'h0000,1,16'h0000,1,1,3'd0,0,0,0,2'd0,16'h0000,0,3'd0,4'd5},  // R5 class 0 clears
        '{1,0,16'h0300,0,16'h0000,0,0,3'd0,0,0,0,2'd0,16'h0000,0,3'd0,4'd9},  // R9 write of 11
        '{1,0,16'h1000,1,16'h0000,0,0,3'd0,1,1,0,2'd0,16'h1000,0,3'd0,4'd4},  // R4 write wins
        '{0,0,16'h0000,1,16'h0000,0,1,3'd2,0,0,0,2'd0,16'h0800,0,3'd0,4'd5}   // R5 float, disabled
    };

    task automatic drive(input vec_t v);
        sw_we = v.we;  user_mode = v.usr; sw_data = v.wdata;
        step = v.stp;  instr_word = v.ins; instr_valid = v.iv;
        ovf_upd = v.ou; ovf_class = v.oc;
        carry_upd = v.cu; carry_in = v.ci;
        cc_upd = v.ccu; cc_in = v.cci;
    endtask

    task automatic chk(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input vec_t v);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
        chk(v.req, "status", status, v.e_stat);
        chk(v.req, "trap_req", trap_req, v.e_trap);
        if (v.e_trap) chk(v.req, "trap_cause", trap_cause, v.e_cause);
    endtask

    function automatic vec_t idle(input logic [15:0] es, input int rq);
        vec_t v = '0;
        v.e_stat = es;
        v.req = rq[3:0];
        return v;
    endfunction

    initial begin
        vec_t v;
        drive('0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        chk(1, "status after reset", status, 16'h0000);
        chk(1, "trap after reset", trap_req, 0);

        for (int i = 0; i < NV; i++) run(VECS[i]);

        // R4: supervisor write sets trap enable and bit 3
        v = idle(16'h3800, 4); v.we = 1; v.wdata = 16'h3800;
        run(v);
        // R11: trapping step, then idle cycle drops the pulse
        v = idle(16'h2800, 11); v.stp = 1; v.ou = 1; v.oc = 3'd1;
        v.e_trap = 1; v.e_cause = 3'd1;
        run(v);
        run(idle(16'h2800, 11));
        // R10: strobe low, no trap, flags kept
        v = idle(16'h2800, 10); v.stp = 1; v.oc = 3'd2; v.ci = 1; v.cci = 2'd2;
        run(v);
        // R1: reset in the middle of operation
        @(negedge clk);
        drive('0);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk(1, "status after mid reset", status, 16'h0000);
        chk(1, "trap after mid reset", trap_req, 0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule